// File: doc/BRIEF.md
# Effective Address Generator for an 8-bit Processor

This block turns an addressing-mode code and its operand bytes into the 16-bit effective address that an 8-bit processor core then uses for its data access. It handles immediate, zero page, zero page plus X or Y, pre-indexed indirect through page zero, post-indexed indirect through page zero, absolute, absolute plus X or Y, absolute indirect and PC-relative addressing. A one-cycle `start` pulse samples the mode, the operand bytes, the index registers, the program counter and the access kind. The result appears with a one-cycle `done` strobe. It is then held until the next accepted start.

The three pointer modes read two pointer bytes through a synchronous read port. Read data arrives one clock after the address is presented. The other modes need no memory access and finish in a single cycle. The historical wrap behaviour is kept on purpose. Zero-page index sums and zero-page pointer fetches never leave page zero. The absolute-indirect pointer never carries into its high byte when the second byte is fetched. An `extra` flag tells the sequencer that the access needs one more cycle. It is raised on a page crossing for indexed reads and when a branch is taken.

Top module: `ea_gen`

## Requirements
- R1: While `rst_n` is low and on the first cycle after its release, `done`, `extra` and `mem_rd` are 0 and `ea` is 0x0000.
- R2: The mode codes are 0 immediate, 1 zero page, 2 zp+X, 3 zp+Y, 4 (zp+X) indirect, 5 (zp)+Y indirect, 6 absolute, 7 abs+X, 8 abs+Y, 9 absolute indirect and 10 relative. Codes 11 to 15 act as absolute. The operand is `{op_hi,op_lo}`. `pc` is the address of the first operand byte. Immediate yields `pc`, zero page yields `{00,op_lo}` and absolute yields `{op_hi,op_lo}`. For every non-pointer mode, `done` is high in the cycle after the start edge.
- R3: Zero page plus X or Y yields `{00, (op_lo+index) mod 256}`. For example, base 0xFF with X=1 gives 0x0000.
- R4: Mode 4 forms p=(op_lo+X) mod 256. It reads the low byte at `{00,p}` and the high byte at `{00,(p+1) mod 256}`. The result is that pointer.
- R5: Mode 5 reads the low byte at `{00,op_lo}` and the high byte at `{00,(op_lo+1) mod 256}`. It then adds Y to the full 16-bit pointer. A pointer at 0xFF takes its high byte from 0x0000.
- R6: Mode 9 reads the low byte at `{op_hi,op_lo}` and the high byte at `{op_hi,(op_lo+1) mod 256}`. A pointer at 0x12FF takes its high byte from 0x1200.
- R7: For modes 5, 7 and 8 with `is_write`=0, `extra` is 1 exactly when adding the index to the low address byte carries into the next page.
- R8: With `is_write`=1, which covers writes and read-modify-writes, `extra` is 0 for modes 5, 7 and 8.
- R9: Mode 10 yields `pc+1` plus `op_lo` taken as a signed byte, with 16-bit wrap. `extra` equals `branch_taken`. All other modes give `extra`=0 apart from R7.
- R10: A pointer mode drives `mem_rd` high in the first and second cycles after the start edge, with the low-byte address first. `done` is high in the fourth cycle. `ea` and `extra` keep their values until the next accepted start. A start while a pointer fetch is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation (accepted when idle) |
| mode | input | 4 | Addressing-mode code |
| op_lo | input | 8 | First operand byte |
| op_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index |
| idx_y | input | 8 | Y index |
| pc | input | 16 | Address of the first operand byte |
| is_write | input | 1 | Write or read-modify-write access |
| branch_taken | input | 1 | Branch condition met (relative mode) |
| mem_addr | output | 16 | Pointer read address |
| mem_rd | output | 1 | Pointer read enable |
| mem_data | input | 8 | Read data, valid one cycle after the address |
| ea | output | 16 | Effective address |
| done | output | 1 | One-cycle result strobe |
| extra | output | 1 | Extra cycle requested |

## Verification
Non-pointer results are due in the cycle after the start edge. Pointer results are due in the fourth cycle, after two read cycles and one cycle for the data to return. The bench samples `done` at each falling edge after the start edge. It requires the strobe to be low until the expected cycle and high there, and it requires `mem_rd` to be high only in the first two cycles. At the expected cycle it compares `ea` and `extra` with a reference model. That model reads the same computed memory contents the bench returns on the read port. Two idle cycles later it checks that the result has not moved.

// File: rtl/ea_gen.sv
module ea_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  mode,
  input  logic [7:0]  op_lo,
  input  logic [7:0]  op_hi,
  input  logic [7:0]  idx_x,
  input  logic [7:0]  idx_y,
  input  logic [15:0] pc,
  input  logic        is_write,
  input  logic        branch_taken,
  output logic [15:0] mem_addr,
  output logic        mem_rd,
  input  logic [7:0]  mem_data,
  output logic [15:0] ea,
  output logic        done,
  output logic        extra
);
  localparam logic [3:0] M_IMM = 4'd0, M_ZP = 4'd1, M_ZPX = 4'd2, M_ZPY = 4'd3,
                         M_IZX = 4'd4, M_IZY = 4'd5, M_ABX = 4'd7,
                         M_ABY = 4'd8, M_IND = 4'd9, M_REL = 4'd10;
  localparam logic [1:0] S_IDLE = 2'd0, S_RLO = 2'd1, S_RHI = 2'd2, S_FIN = 2'd3;

  logic [1:0]  st;
  logic [3:0]  mode_r;
  logic [15:0] base_r;
  logic [7:0]  y_r, lo_r;
  logic        wr_r;

  logic [15:0] abs16, d_ea, p_base, f_ea;
  logic [8:0]  sum_x, sum_y, sum_py;
  logic        d_ex, f_ex, is_ptr;

  assign abs16  = {op_hi, op_lo};
  assign sum_x  = {1'b0, op_lo} + {1'b0, idx_x};
  assign sum_y  = {1'b0, op_lo} + {1'b0, idx_y};
  assign sum_py = {1'b0, lo_r} + {1'b0, y_r};
  assign is_ptr = (mode == M_IZX) || (mode == M_IZY) || (mode == M_IND);

  always_comb begin
    d_ex = 1'b0;
    case (mode)
      M_IMM: d_ea = pc;
      M_ZP:  d_ea = {8'h00, op_lo};
      M_ZPX: d_ea = {8'h00, sum_x[7:0]};
      M_ZPY: d_ea = {8'h00, sum_y[7:0]};
      M_ABX: begin d_ea = abs16 + {8'h00, idx_x}; d_ex = sum_x[8] & ~is_write; end
      M_ABY: begin d_ea = abs16 + {8'h00, idx_y}; d_ex = sum_y[8] & ~is_write; end
      M_REL: begin d_ea = pc + 16'd1 + {{8{op_lo[7]}}, op_lo}; d_ex = branch_taken; end
      default: d_ea = abs16;
    endcase
  end

  always_comb begin
    case (mode)
      M_IZX:   p_base = {8'h00, sum_x[7:0]};
      M_IZY:   p_base = {8'h00, op_lo};
      default: p_base = abs16;
    endcase
  end

  always_comb begin
    if (mode_r == M_IZY) begin
      f_ea = {mem_data, lo_r} + {8'h00, y_r};
      f_ex = sum_py[8] & ~wr_r;
    end else begin
      f_ea = {mem_data, lo_r};
      f_ex = 1'b0;
    end
  end

  assign mem_rd   = (st == S_RLO) || (st == S_RHI);
  assign mem_addr = (st == S_RHI) ? {base_r[15:8], base_r[7:0] + 8'd1} : base_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; mode_r <= '0; base_r <= '0; y_r <= '0; lo_r <= '0; wr_r <= 1'b0;
      ea <= '0; done <= 1'b0; extra <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          mode_r <= mode;
          wr_r   <= is_write;
          if (is_ptr) begin
            base_r <= p_base;
            y_r    <= idx_y;
            st     <= S_RLO;
          end else begin
            ea    <= d_ea;
            extra <= d_ex;
            done  <= 1'b1;
          end
        end
        S_RLO: st <= S_RHI;
        S_RHI: begin lo_r <= mem_data; st <= S_FIN; end
        default: begin
          ea    <= f_ea;
          extra <= f_ex;
          done  <= 1'b1;
          st    <= S_IDLE;
        end
      endcase
    end
  end

  a_r4_zp_pointer_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && mode_r != M_IND |-> mem_addr[15:8] == 8'h00);
  a_r6_no_high_carry: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && $past(mem_rd) |-> mem_addr[15:8] == $past(mem_addr[15:8]));
  a_r8_write_no_extra: assert property (@(posedge clk) disable iff (!rst_n)
    done && wr_r && mode_r != M_REL |-> !extra);
  a_r10_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(ea) && $stable(extra));
  a_r10_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd) |=> mem_rd);
  a_r10_done_after_reads: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd) |=> done);
endmodule

// File: tb/sim_ea_gen.sv
`timescale 1ns/1ps
module sim_ea_gen;
  logic clk = 0, rst_n = 0, start = 0, is_write = 0, branch_taken = 0;
  logic [3:0] mode = 0;
  logic [7:0] op_lo = 0, op_hi = 0, idx_x = 0, idx_y = 0, mem_data = 0;
  logic [15:0] pc = 0, mem_addr, ea;
  logic mem_rd, done, extra;
  int vec = 0, bad = 0;

  always #10 clk = ~clk;

  ea_gen u0 (.clk, .rst_n, .start, .mode, .op_lo, .op_hi, .idx_x, .idx_y, .pc,
             .is_write, .branch_taken, .mem_addr, .mem_rd, .mem_data, .ea, .done, .extra);

  function automatic logic [7:0] mf(input logic [15:0] a);
    return a[7:0] ^ (a[15:8] * 8'd3) ^ 8'hA5;
  endfunction

  always @(posedge clk) if (mem_rd) mem_data <= mf(mem_addr);

  function automatic logic [16:0] ref_ea(input logic [3:0] m, input logic [7:0] lo, hi, x, y,
                                         input logic [15:0] p, input logic wr, tk);
    logic [7:0] z; logic [15:0] ptr, r; logic [8:0] s; logic ex;
    ex = 0;
    case (m)
      0: r = p;
      1: r = {8'h00, lo};
      2: r = {8'h00, lo + x};
      3: r = {8'h00, lo + y};
      4: begin z = lo + x; r = {mf({8'h00, z + 8'd1}), mf({8'h00, z})}; end
      5: begin ptr = {mf({8'h00, lo + 8'd1}), mf({8'h00, lo})};
               r = ptr + {8'h00, y}; s = {1'b0, ptr[7:0]} + {1'b0, y}; ex = s[8] & ~wr; end
      7: begin r = {hi, lo} + {8'h00, x}; s = {1'b0, lo} + {1'b0, x}; ex = s[8] & ~wr; end
      8: begin r = {hi, lo} + {8'h00, y}; s = {1'b0, lo} + {1'b0, y}; ex = s[8] & ~wr; end
      9: r = {mf({hi, lo + 8'd1}), mf({hi, lo})};
      10: begin r = p + 16'd1 + {{8{lo[7]}}, lo}; ex = tk; end
      default: r = {hi, lo};
    endcase
    return {ex, r};
  endfunction

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      2, 3: return "R3";
      4: return "R4";
      5: return "R5";
      7, 8: return "R7";
      9: return "R6";
      10: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input logic [31:0] act, exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] m, input logic [7:0] lo, hi, x, y,
                     input logic [15:0] p, input logic wr, tk);
    logic [16:0] e; int lat; bit ptrm; string t, tx;
    e = ref_ea(m, lo, hi, x, y, p, wr, tk);
    ptrm = (m == 4) || (m == 5) || (m == 9);
    lat = ptrm ? 4 : 1;
    t = tag_of(m);
    tx = (wr && (m == 5 || m == 7 || m == 8)) ? "R8" : ((m == 5 || m == 7 || m == 8 || m == 10) ? t : "R9");
    @(negedge clk);
    mode = m; op_lo = lo; op_hi = hi; idx_x = x; idx_y = y; pc = p; is_write = wr; branch_taken = tk;
    start = 1;
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      start = 0;
      if (k < lat) chk(!done, "R10", "done early", {31'b0, done}, 0);
      else chk(done, ptrm ? "R10" : "R2", "done missing", {31'b0, done}, 1);
      if (ptrm) chk(mem_rd == (k <= 2), "R10", "mem_rd", {31'b0, mem_rd}, {31'b0, k <= 2});
    end
    chk(ea == e[15:0], t, "ea", {16'b0, ea}, {16'b0, e[15:0]});
    chk(extra == e[16], tx, "extra", {31'b0, extra}, {31'b0, e[16]});
    mode = 4'd6; op_lo = ~lo; op_hi = ~hi; pc = ~p;
    @(negedge clk); @(negedge clk);
    chk(ea == e[15:0] && !done, "R10", "result held", {15'b0, done, ea}, {16'b0, e[15:0]});
  endtask

  initial begin
    #(20ns * 200000);
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd7331);
    @(negedge clk); @(negedge clk);
    chk(!done && !extra && !mem_rd && ea == 0, "R1", "reset state", {13'b0, done, extra, mem_rd, ea}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !extra && !mem_rd && ea == 0, "R1", "after reset", {13'b0, done, extra, mem_rd, ea}, 0);
    run(0, 8'h12, 8'h34, 0, 0, 16'hC001, 0, 0);
    run(1, 8'h80, 8'h34, 0, 0, 16'hC001, 0, 0);
    run(6, 8'hCD, 8'hAB, 0, 0, 16'h0000, 0, 0);
    run(2, 8'hFF, 8'h00, 8'h01, 0, 16'h0, 0, 0);
    run(3, 8'hF0, 8'h00, 0, 8'h20, 16'h0, 0, 0);
    run(4, 8'hFF, 8'h00, 8'h00, 0, 16'h0, 0, 0);
    run(4, 8'h00, 8'h00, 8'hFF, 0, 16'h0, 0, 0);
    run(5, 8'hFF, 8'h00, 0, 8'hFF, 16'h0, 0, 0);
    run(5, 8'hFF, 8'h00, 0, 8'hFF, 16'h0, 1, 0);
    run(9, 8'hFF, 8'h12, 0, 0, 16'h0, 0, 0);
    run(7, 8'hF0, 8'h20, 8'h10, 0, 16'h0, 0, 0);
    run(7, 8'hF0, 8'h20, 8'h0F, 0, 16'h0, 0, 0);
    run(8, 8'hF0, 8'h20, 0, 8'h10, 16'h0, 1, 0);
    run(10, 8'h80, 8'h00, 0, 0, 16'h0010, 0, 1);
    run(10, 8'h7F, 8'h00, 0, 0, 16'hFFF0, 0, 0);
    run(12, 8'h11, 8'h22, 0, 0, 16'h0, 0, 0);
    for (int i = 0; i < 300; i++) begin
      logic [3:0] m;
      m = 4'($urandom_range(0, 15));
      run(m, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 16'($urandom),
          1'($urandom), 1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule